// File: doc/BRIEF.md
# PWM Output Action Qualifier with Shadowed Software Force

This block sets the level of two PWM outputs, A and B. It takes strobes from a time-base counter: counter at zero, counter at period, and up-count matches against compare A and compare B. It updates the outputs only on cycles where the tick enable is high. Each output has its own action word. The word gives every event a 2-bit action: do nothing, drive low, drive high or toggle. For example, an output goes high at period and low on its compare match. Swapping those two actions inverts the polarity.

Software can also force either output low or high continuously. It writes the force value into a shadow register. A reload-mode setting then chooses the tick at which the shadow value becomes active: a zero tick, a period tick, either of those, or every tick. While a force is active, it replaces all event actions for that output. The time-base counter and the comparators sit outside this block.

Top module: `pwm_action_qualifier`

## Requirements
- R1: After reset both outputs are low, both action words are all no-action, the shadow and active force values are cleared, and the reload mode is 00.
- R2: An action code of 00 means no action, 01 drives low, 10 drives high and 11 toggles. Each action word holds four fields: zero event in bits 1:0, period event in bits 3:2, compare-A-up in bits 5:4, and compare-B-up in bits 9:8. The resulting level appears after the clock edge on which tickEn is high.
- R3: When tickEn is low, the outputs hold their level whatever the event strobes are.
- R4: If several strobes arrive in one tick, the output takes the action of the highest-priority strobe whose field is not 00. The order, highest first, is compare-B-up, compare-A-up, period, zero.
- R5: Writes are decoded by wrAddr, using the bits of wrData as follows:
  - address 0 loads the output A action word.
  - address 1 loads the output B action word.
  - address 2 loads the shadow force, with output A in bits 1:0 and output B in bits 3:2.
  - address 3 loads the reload mode from bits 7:6.
  A write changes only the register it addresses.
- R6: An active force code of 01 drives the output low at every tick, and 10 drives it high, overriding all event actions. Codes 00 and 11 leave the output to the events.
- R7: The shadow force is copied to the active force on a tick, at a point set by the reload mode:
  - mode 00: a tick with the zero strobe.
  - mode 01: a tick with the period strobe.
  - mode 10: a tick with either strobe.
  - mode 11: every tick.
  The newly loaded value already governs the output at the tick that loads it. Until then, a shadow write has no effect on the outputs.
- R8: If a shadow write and a reload tick fall in the same cycle, the active force takes the shadow value from before the write. The new value applies from the next reload tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Time-base tick enable; events act only when high |
| evZero | input | 1 | Counter-equals-zero strobe |
| evPeriod | input | 1 | Counter-equals-period strobe |
| evCmpAUp | input | 1 | Up-count match on compare A |
| evCmpBUp | input | 1 | Up-count match on compare B |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (see R5) |
| wrData | input | 10 | Register write data |
| pwmA | output | 1 | Output A level |
| pwmB | output | 1 | Output B level |

## Verification
Every result lags its cause by exactly one register stage. Output levels, register writes and force reloads all appear after the rising edge that samples the stimulus. The bench drives each stimulus just after a falling edge and lets one rising edge pass. It then compares both outputs against its own model at the next falling edge. The model updates in the same edge order as the hardware: reload decision, then output level, then register writes. This is what makes the same-cycle write-and-reload case (R8) predictable.

// File: rtl/pwm_aq_pkg.sv
`timescale 1ns/1ps
package pwm_aq_pkg;
  localparam int NUM_OUT  = 2;
  localparam int ACT_W    = 2;
  localparam int CTL_W    = 10;
  localparam int ADDR_W   = 2;
  localparam int FORCE_W  = ACT_W * NUM_OUT;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } reload_e;

  // Stored form of one action word: the four decoded event fields
  typedef struct packed {
    act_e onCmpB;
    act_e onCmpA;
    act_e onPeriod;
    act_e onZero;
  } actWord_t;

  // Strobes from the control to the datapath, one set per output
  typedef struct packed {
    logic drvLow;
    logic drvHigh;
    logic flip;
  } outCmd_t;
endpackage

// File: rtl/pwm_aq_ctrl.sv
`timescale 1ns/1ps
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tickEn,
  input  logic                        evZero,
  input  logic                        evPeriod,
  input  logic                        evCmpA,
  input  logic                        evCmpB,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [CTL_W-1:0]            wrData,
  output outCmd_t [NUM_OUT-1:0]       cmd
);
  localparam logic [ADDR_W-1:0] ADDR_FORCE  = ADDR_W'(NUM_OUT);
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = ADDR_W'(NUM_OUT + 1);

  actWord_t [NUM_OUT-1:0] acts;
  logic [FORCE_W-1:0]     shadowForce;
  logic [FORCE_W-1:0]     activeForce;
  logic [FORCE_W-1:0]     effForce;
  reload_e                reloadMode;
  logic                   reloadHit;
  logic                   reloadNow;

  always_comb begin
    unique case (reloadMode)
      RLD_ZERO:   reloadHit = evZero;
      RLD_PERIOD: reloadHit = evPeriod;
      RLD_EITHER: reloadHit = evZero | evPeriod;
      default:    reloadHit = 1'b1;
    endcase
  end

  assign reloadNow = tickEn & reloadHit;
  // A value loaded on this tick already governs this tick
  assign effForce  = reloadNow ? shadowForce : activeForce;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acts        <= '0;
      shadowForce <= '0;
      activeForce <= '0;
      reloadMode  <= RLD_ZERO;
    end else begin
      if (reloadNow) activeForce <= shadowForce;
      if (wrEn) begin
        for (int i = 0; i < NUM_OUT; i++) begin
          if (wrAddr == ADDR_W'(i)) begin
            acts[i] <= '{onCmpB:   act_e'(wrData[9:8]),
                         onCmpA:   act_e'(wrData[5:4]),
                         onPeriod: act_e'(wrData[3:2]),
                         onZero:   act_e'(wrData[1:0])};
          end
        end
        if (wrAddr == ADDR_FORCE)  shadowForce <= wrData[FORCE_W-1:0];
        if (wrAddr == ADDR_RELOAD) reloadMode  <= reload_e'(wrData[7:6]);
      end
    end
  end

  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(activeForce)); // R7
  AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && reloadMode == RLD_NOW) |=> activeForce == $past(shadowForce)); // R8

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    act_e       chosen;
    logic [1:0] fc;
    logic       forced;

    // Later tests override earlier ones: zero < period < cmpA < cmpB
    always_comb begin
      chosen = ACT_NONE;
      if (evZero   && acts[g].onZero   != ACT_NONE) chosen = acts[g].onZero;
      if (evPeriod && acts[g].onPeriod != ACT_NONE) chosen = acts[g].onPeriod;
      if (evCmpA   && acts[g].onCmpA   != ACT_NONE) chosen = acts[g].onCmpA;
      if (evCmpB   && acts[g].onCmpB   != ACT_NONE) chosen = acts[g].onCmpB;
    end

    assign fc     = effForce[ACT_W*g +: ACT_W];
    assign forced = (fc == 2'b01) || (fc == 2'b10);

    assign cmd[g].drvLow  = tickEn & (forced ? (fc == 2'b01) : (chosen == ACT_LOW));
    assign cmd[g].drvHigh = tickEn & (forced ? (fc == 2'b10) : (chosen == ACT_HIGH));
    assign cmd[g].flip    = tickEn & ~forced & (chosen == ACT_TOGGLE);

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({cmd[g].drvLow, cmd[g].drvHigh, cmd[g].flip})); // R4
  end
endmodule

// File: rtl/pwm_aq_datapath.sv
`timescale 1ns/1ps
module pwm_aq_datapath
  import pwm_aq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  outCmd_t [NUM_OUT-1:0] cmd,
  output logic [NUM_OUT-1:0]    pwm
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwm <= '0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (cmd[i].drvLow)       pwm[i] <= 1'b0;
        else if (cmd[i].drvHigh) pwm[i] <= 1'b1;
        else if (cmd[i].flip)    pwm[i] <= ~pwm[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      cmd[g].drvHigh |=> pwm[g]); // R2
    AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      cmd[g].drvLow |=> !pwm[g]); // R6
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
      cmd[g].flip |=> pwm[g] != $past(pwm[g])); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (cmd[g] == '0) |=> $stable(pwm[g])); // R3
  end
endmodule

// File: rtl/pwm_action_qualifier.sv
`timescale 1ns/1ps
module pwm_action_qualifier
  import pwm_aq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              evZero,
  input  logic              evPeriod,
  input  logic              evCmpAUp,
  input  logic              evCmpBUp,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTL_W-1:0]  wrData,
  output logic              pwmA,
  output logic              pwmB
);
  outCmd_t [NUM_OUT-1:0] cmd;
  logic [NUM_OUT-1:0]    pwm;

  pwm_aq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .evZero   (evZero),
    .evPeriod (evPeriod),
    .evCmpA   (evCmpAUp),
    .evCmpB   (evCmpBUp),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .cmd      (cmd)
  );

  pwm_aq_datapath u_dp (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .pwm  (pwm)
  );

  assign pwmA = pwm[0];
  assign pwmB = pwm[1];
endmodule

// File: tb/pwm_action_qualifier_tb.sv
`timescale 1ns/1ps
module pwm_action_qualifier_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       evZero = 1'b0, evPeriod = 1'b0, evCmpAUp = 1'b0, evCmpBUp = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic       pwmA, pwmB;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Reference model state
  logic [9:0] mCtl [2];
  logic [3:0] mShadow, mActive;
  logic [1:0] mMode;
  logic       mPwm [2];

  always #10 clk = ~clk;

  pwm_action_qualifier u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .evZero(evZero), .evPeriod(evPeriod), .evCmpAUp(evCmpAUp), .evCmpBUp(evCmpBUp),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmA(pwmA), .pwmB(pwmB)
  );

  function automatic logic [1:0] pickAct(input logic [9:0] w, input logic [3:0] ev);
    if (ev[3] && w[9:8] != 2'b00) return w[9:8];
    if (ev[2] && w[5:4] != 2'b00) return w[5:4];
    if (ev[1] && w[3:2] != 2'b00) return w[3:2];
    if (ev[0] && w[1:0] != 2'b00) return w[1:0];
    return 2'b00;
  endfunction

  task automatic checkOuts();
    checks++;
    if (pwmA !== mPwm[0]) begin
      errors++;
      $display("FAIL %s pwmA actual %b expected %b", curReq, pwmA, mPwm[0]);
    end
    checks++;
    if (pwmB !== mPwm[1]) begin
      errors++;
      $display("FAIL %s pwmB actual %b expected %b", curReq, pwmB, mPwm[1]);
    end
  endtask

  // ev = {cmpB, cmpA, period, zero}
  task automatic step(input logic we, input logic [1:0] ad, input logic [9:0] dat,
                      input logic te, input logic [3:0] ev);
    logic       rl;
    logic [3:0] eff;
    logic [1:0] f, a;
    wrEn = we; wrAddr = ad; wrData = dat; tickEn = te;
    evZero = ev[0]; evPeriod = ev[1]; evCmpAUp = ev[2]; evCmpBUp = ev[3];
    @(posedge clk);
    case (mMode)
      2'b00:   rl = te && ev[0];
      2'b01:   rl = te && ev[1];
      2'b10:   rl = te && (ev[0] || ev[1]);
      default: rl = te;
    endcase
    eff = rl ? mShadow : mActive;
    if (te) begin
      for (int i = 0; i < 2; i++) begin
        f = eff[2*i +: 2];
        if (f == 2'b01)      mPwm[i] = 1'b0;
        else if (f == 2'b10) mPwm[i] = 1'b1;
        else begin
          a = pickAct(mCtl[i], ev);
          if (a == 2'b01)      mPwm[i] = 1'b0;
          else if (a == 2'b10) mPwm[i] = 1'b1;
          else if (a == 2'b11) mPwm[i] = ~mPwm[i];
        end
      end
    end
    if (rl) mActive = mShadow;
    if (we) begin
      case (ad)
        2'd0: mCtl[0] = dat;
        2'd1: mCtl[1] = dat;
        2'd2: mShadow = dat[3:0];
        default: mMode = dat[7:6];
      endcase
    end
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    evZero = 1'b0; evPeriod = 1'b0; evCmpAUp = 1'b0; evCmpBUp = 1'b0;
    checkOuts();
  endtask

  task automatic wr(input logic [1:0] ad, input logic [9:0] dat);
    step(1'b1, ad, dat, 1'b0, 4'b0000);
  endtask

  task automatic tick(input logic [3:0] ev);
    step(1'b0, 2'd0, 10'd0, 1'b1, ev);
  endtask

  function automatic logic [9:0] mkWord(input logic [7:0] w);
    return {w[7:6], 2'b00, w[5:4], w[3:2], w[1:0]};
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired during %s", curReq);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mCtl[0] = '0; mCtl[1] = '0; mShadow = '0; mActive = '0; mMode = '0;
    mPwm[0] = 1'b0; mPwm[1] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, cleared config, reload mode 00
    curReq = "R1";
    checkOuts();
    tick(4'b1111);
    wr(2'd2, 10'b1010);
    tick(4'b0010);       // period tick: no reload in mode 00
    tick(4'b0001);       // zero tick: force high takes effect
    wr(2'd2, 10'b0000);
    tick(4'b0001);

    // R2 / R4: sweep all action words for A, derived words for B, all event sets
    for (int w = 0; w < 256; w++) begin
      wr(2'd0, mkWord(8'(w)));
      wr(2'd1, mkWord(8'((w * 37 + 11) & 255)));
      for (int m = 0; m < 16; m++) begin
        curReq = ($countones(m) > 1) ? "R4" : "R2";
        tick(4'(m));
      end
    end

    // R3: tick enable low ignores all strobes
    curReq = "R3";
    wr(2'd0, 10'h33F);
    wr(2'd1, 10'h2AA);
    for (int m = 0; m < 16; m++) step(1'b0, 2'd0, 10'd0, 1'b0, 4'(m));

    // R5: address decode; the reload write's low bits leave the shadow alone
    curReq = "R5";
    wr(2'd0, 10'h002);
    wr(2'd1, 10'h001);
    wr(2'd3, 10'h0CF);
    tick(4'b0001);
    tick(4'b0001);

    // R6 / R7: every reload mode against every force pair
    wr(2'd0, 10'h33F);
    wr(2'd1, 10'h30F);
    for (int md = 0; md < 4; md++) begin
      for (int fv = 0; fv < 16; fv++) begin
        curReq = (md == 3) ? "R6" : "R7";
        wr(2'd3, 10'(md << 6));
        wr(2'd2, 10'(fv));
        tick(4'b0100);
        tick(4'b0010);
        tick(4'b1000);
        tick(4'b0001);
        tick(4'b0011);
        tick(4'b0000);
      end
    end

    // R8: shadow write coinciding with an immediate reload tick
    curReq = "R8";
    wr(2'd3, 10'h0C0);
    wr(2'd2, 10'b0101);
    tick(4'b0000);
    wr(2'd2, 10'b0000);
    step(1'b1, 2'd2, 10'b1010, 1'b1, 4'b0000);
    tick(4'b0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule